// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block decides which interrupt a processor should take next. Three internal sources (power failure, trapped operation code, control error) rank above eight external request lines. External lines are level inputs captured into a sticky pending register. A program-loaded enable mask gates each captured line, and a block flag holds back external service while one is in progress. The block presents the winning request together with a vector address. Internal sources each have a fixed vector; external line `i` uses `EXT_BASE + i`.

The request leaves the block on a valid/ready pair. `irq_valid` stays high for as long as any eligible request is pending. `irq_vec` always names the current winner, so a higher-priority arrival may change it before acceptance. A request is taken only in a cycle where both `irq_valid` and `irq_ready` are high. Holding `irq_ready` low loses nothing, because every source stays pending.

A taken external request leaves its pending bit set. Software clears it through the clear port. Taking it sets the block flag, and from then on only external lines of strictly higher priority can be presented until software releases the flag. Internal requests are dropped from pending once taken, and they never touch the block flag. The mask is written from the program side either by a plain load or by an exchange that also returns the previous mask.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending, mask and block state are clear, and `irq_valid`, `ack_valid` and `mask_old` are 0.
- R2: A high level on `ext_req[i]` in any one cycle makes line `i` pending from the next cycle on. It stays pending, including after it has been taken, until the clear port removes it. An unmasked, unblocked pending line `i` is presented with `irq_vec = EXT_BASE + i`.
- R3: An external line whose mask bit is 0 is never presented, however long it stays pending.
- R4: Among eligible external lines, the lowest index wins.
- R5: Internal source bit 0 (power failure, vector `VEC_PFAIL`) beats bit 1 (trapped op-code, `VEC_TRAP`), which beats bit 2 (control error, `VEC_CERR`). Any pending internal source beats every external line. Internal sources ignore both the mask and the block flag.
- R6: A request is taken in a cycle with `irq_valid` and `irq_ready` both high. In the next cycle, and only then, `ack_valid` is 1, with `ack_int` (1 = internal) and `ack_line` (line index, or internal bit number) naming the taken source. A taken internal source leaves pending.
- R7: Taking external line `L` sets the block flag and records `L`. While the flag is set, only external lines with index below the recorded level are presented.
- R8: `blk_set` sets the flag with a recorded level of 0, which holds all external lines. `blk_clr` clears the flag. When both are high in the same cycle, the set wins. `blk_set` also overrides the level recorded by a same-cycle external take.
- R9: A 1 in `ext_clr[i]` removes pending line `i`. If `ext_req[i]` is high in the same cycle, the clear still wins for that cycle.
- R10: `mask_ld` loads `mask_wdata` into the mask and leaves `mask_old` alone. `mask_xchg` loads `mask_wdata` and puts the previous mask on `mask_old` in the next cycle. If both are high, the exchange is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req | input | 3 | Internal request levels, bit 0 highest |
| ext_req | input | N_EXT | External request levels, bit 0 highest |
| ext_clr | input | N_EXT | Program clear of pending external lines |
| mask_ld | input | 1 | Load mask from `mask_wdata` |
| mask_xchg | input | 1 | Exchange mask with `mask_wdata` |
| mask_wdata | input | N_EXT | New mask value |
| mask_old | output | N_EXT | Mask value replaced by the last exchange |
| blk_set | input | 1 | Set block flag (holds all external lines) |
| blk_clr | input | 1 | Release block flag |
| irq_valid | output | 1 | An eligible request is pending |
| irq_ready | input | 1 | Processor takes the presented request |
| irq_vec | output | VEC_W | Vector address of the presented request |
| ack_valid | output | 1 | One-cycle acknowledge of a taken request |
| ack_int | output | 1 | Acknowledged source is internal |
| ack_line | output | LW | Index of the acknowledged source |

## Verification
Single-line arrivals separate capture and vector forming from arbitration. Overlapping external lines with the mask open check index priority, and the same lines under a closed mask check gating. Requests arriving while the block flag is set show the difference between blocking all lines, blocking only lower-priority ones, and the always-pass path for internal sources. Same-cycle conflicts (clear against a new level, set against release, exchange against load) and a long random mix with a stalling `irq_ready`, compared cycle by cycle with a behavioural model, show whether any state is lost or altered under back-pressure.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int N_INT = 3;
  localparam int SRC_PFAIL = 0;
  localparam int SRC_TRAP  = 1;
  localparam int SRC_CERR  = 2;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_INT  = 2'd1,
    KIND_EXT  = 2'd2
  } pick_kind_e;
endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg
  import irq_prio_pkg::*;
#(
  parameter int N_EXT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_INT-1:0] int_req,
  input  logic [N_INT-1:0] int_take,
  input  logic [N_EXT-1:0] ext_req,
  input  logic [N_EXT-1:0] ext_clr,
  output logic [N_INT-1:0] pend_int,
  output logic [N_EXT-1:0] pend_ext
);
  // Sticky capture: a level sets the bit, only an explicit clear removes it.
  // The clear is applied after the capture, so it wins in a shared cycle.
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_ext[g] <= 1'b0;
      else        pend_ext[g] <= (pend_ext[g] | ext_req[g]) & ~ext_clr[g];
    end
  end

  for (genvar k = 0; k < N_INT; k++) begin : g_int
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_int[k] <= 1'b0;
      else        pend_int[k] <= (pend_int[k] | int_req[k]) & ~int_take[k];
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N_EXT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_ld,
  input  logic             mask_xchg,
  input  logic [N_EXT-1:0] mask_wdata,
  output logic [N_EXT-1:0] mask_q,
  output logic [N_EXT-1:0] mask_old
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      mask_old <= '0;
    end else if (mask_xchg) begin
      mask_old <= mask_q;
      mask_q   <= mask_wdata;
    end else if (mask_ld) begin
      mask_q   <= mask_wdata;
    end
  end
endmodule

// File: rtl/irq_block_ctrl.sv
module irq_block_ctrl #(
  parameter int N_EXT = 8,
  parameter int LW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_set,
  input  logic             blk_clr,
  input  logic             ext_take,
  input  logic [LW-1:0]    take_line,
  output logic             blk_q,
  output logic [LW-1:0]    serv_lvl,
  output logic [N_EXT-1:0] allow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q    <= 1'b0;
      serv_lvl <= '0;
    end else begin
      blk_q <= (blk_q & ~blk_clr) | blk_set | ext_take;
      if (blk_set)       serv_lvl <= '0;
      else if (ext_take) serv_lvl <= take_line;
    end
  end

  // While blocked, a line passes only if it outranks the recorded level.
  for (genvar g = 0; g < N_EXT; g++) begin : g_allow
    assign allow[g] = !blk_q || (LW'(g) < serv_lvl);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int          N_EXT     = 8,
  parameter int          LW        = 3,
  parameter int          VEC_W     = 15,
  parameter int unsigned EXT_BASE  = 64,
  parameter int unsigned VEC_PFAIL = 16,
  parameter int unsigned VEC_TRAP  = 17,
  parameter int unsigned VEC_CERR  = 18
) (
  input  logic [N_INT-1:0] pend_int,
  input  logic [N_EXT-1:0] elig_ext,
  output pick_kind_e       kind,
  output logic [LW-1:0]    line,
  output logic [VEC_W-1:0] vec
);
  localparam logic [N_INT*VEC_W-1:0] INT_VECS =
    {VEC_W'(VEC_CERR), VEC_W'(VEC_TRAP), VEC_W'(VEC_PFAIL)};
  localparam logic [VEC_W-1:0] BASE = VEC_W'(EXT_BASE);

  // Scan from the lowest priority upward so the last hit is the winner;
  // the internal scan runs second and overrides any external pick.
  always_comb begin
    kind = KIND_NONE;
    line = '0;
    vec  = '0;
    for (int i = N_EXT - 1; i >= 0; i--) begin
      if (elig_ext[i]) begin
        kind = KIND_EXT;
        line = LW'(i);
        vec  = BASE + VEC_W'(i);
      end
    end
    for (int k = N_INT - 1; k >= 0; k--) begin
      if (pend_int[k]) begin
        kind = KIND_INT;
        line = LW'(k);
        vec  = INT_VECS[k*VEC_W +: VEC_W];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int          N_EXT     = 8,
  parameter int          VEC_W     = 15,
  parameter int unsigned EXT_BASE  = 64,
  parameter int unsigned VEC_PFAIL = 16,
  parameter int unsigned VEC_TRAP  = 17,
  parameter int unsigned VEC_CERR  = 18,
  localparam int         LW        = ($clog2(N_EXT) < 2) ? 2 : $clog2(N_EXT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       int_req,
  input  logic [N_EXT-1:0] ext_req,
  input  logic [N_EXT-1:0] ext_clr,
  input  logic             mask_ld,
  input  logic             mask_xchg,
  input  logic [N_EXT-1:0] mask_wdata,
  output logic [N_EXT-1:0] mask_old,
  input  logic             blk_set,
  input  logic             blk_clr,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vec,
  output logic             ack_valid,
  output logic             ack_int,
  output logic [LW-1:0]    ack_line
);
  logic [N_INT-1:0] pend_int;
  logic [N_EXT-1:0] pend_ext;
  logic [N_EXT-1:0] mask_q;
  logic [N_EXT-1:0] allow;
  logic [N_EXT-1:0] elig_ext;
  logic             blk_q;
  logic [LW-1:0]    serv_lvl;
  pick_kind_e       sel_kind;
  logic [LW-1:0]    sel_line;
  logic             accept;
  logic             ext_take;
  logic [N_INT-1:0] int_take;

  irq_pending_reg #(.N_EXT(N_EXT)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_req  (int_req),
    .int_take (int_take),
    .ext_req  (ext_req),
    .ext_clr  (ext_clr),
    .pend_int (pend_int),
    .pend_ext (pend_ext)
  );

  irq_mask_reg #(.N_EXT(N_EXT)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_ld    (mask_ld),
    .mask_xchg  (mask_xchg),
    .mask_wdata (mask_wdata),
    .mask_q     (mask_q),
    .mask_old   (mask_old)
  );

  irq_block_ctrl #(.N_EXT(N_EXT), .LW(LW)) u_blk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_set   (blk_set),
    .blk_clr   (blk_clr),
    .ext_take  (ext_take),
    .take_line (sel_line),
    .blk_q     (blk_q),
    .serv_lvl  (serv_lvl),
    .allow     (allow)
  );

  assign elig_ext = pend_ext & mask_q & allow;

  irq_arbiter #(
    .N_EXT(N_EXT), .LW(LW), .VEC_W(VEC_W), .EXT_BASE(EXT_BASE),
    .VEC_PFAIL(VEC_PFAIL), .VEC_TRAP(VEC_TRAP), .VEC_CERR(VEC_CERR)
  ) u_arb (
    .pend_int (pend_int),
    .elig_ext (elig_ext),
    .kind     (sel_kind),
    .line     (sel_line),
    .vec      (irq_vec)
  );

  assign irq_valid = (sel_kind != KIND_NONE);
  assign accept    = irq_valid & irq_ready;
  assign ext_take  = accept && (sel_kind == KIND_EXT);
  assign int_take  = (accept && (sel_kind == KIND_INT)) ? (N_INT'(1) << sel_line) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_int   <= 1'b0;
      ack_line  <= '0;
    end else begin
      ack_valid <= accept;
      if (accept) begin
        ack_int  <= (sel_kind == KIND_INT);
        ack_line <= sel_line;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int N_EXT = 8,
  parameter int LW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic             ack_valid,
  input pick_kind_e       sel_kind,
  input logic [LW-1:0]    sel_line,
  input logic [N_EXT-1:0] mask_q,
  input logic [N_EXT-1:0] mask_old,
  input logic             mask_xchg,
  input logic             blk_q,
  input logic [LW-1:0]    serv_lvl,
  input logic [N_INT-1:0] pend_int,
  input logic [N_EXT-1:0] pend_ext,
  input logic [N_EXT-1:0] ext_clr
);
  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> ack_valid); // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid && irq_ready) |=> !ack_valid); // R6
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && sel_kind == KIND_EXT) |-> mask_q[sel_line]); // R3
  AST_INT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_int != '0) |-> (irq_valid && sel_kind == KIND_INT)); // R5
  AST_BLOCK_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && sel_kind == KIND_EXT) |=> blk_q); // R7
  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && irq_valid && sel_kind == KIND_EXT) |-> (sel_line < serv_lvl)); // R7
  AST_XCHG_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_xchg |=> (mask_old == $past(mask_q))); // R10
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clr != '0) |=> ((pend_ext & $past(ext_clr)) == '0)); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(pend_ext) & ~$past(ext_clr) & ~pend_ext) == '0)); // R2
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_EXT(N_EXT), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_valid (irq_valid),
  .irq_ready (irq_ready),
  .ack_valid (ack_valid),
  .sel_kind  (sel_kind),
  .sel_line  (sel_line),
  .mask_q    (mask_q),
  .mask_old  (mask_old),
  .mask_xchg (mask_xchg),
  .blk_q     (blk_q),
  .serv_lvl  (serv_lvl),
  .pend_int  (pend_int),
  .pend_ext  (pend_ext),
  .ext_clr   (ext_clr)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] int_req = '0;
  logic [N-1:0] ext_req = '0, ext_clr = '0, mask_wdata = '0;
  logic       mask_ld = 1'b0, mask_xchg = 1'b0, blk_set = 1'b0, blk_clr = 1'b0;
  logic       irq_ready = 1'b0;
  logic [N-1:0] mask_old;
  logic       irq_valid, ack_valid, ack_int;
  logic [14:0] irq_vec;
  logic [2:0] ack_line;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .ext_req(ext_req),
    .ext_clr(ext_clr), .mask_ld(mask_ld), .mask_xchg(mask_xchg),
    .mask_wdata(mask_wdata), .mask_old(mask_old), .blk_set(blk_set),
    .blk_clr(blk_clr), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vec(irq_vec), .ack_valid(ack_valid), .ack_int(ack_int),
    .ack_line(ack_line)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0]   m_pint;
  logic [N-1:0] m_pext, m_mask, m_old;
  bit           m_blk, m_ack, m_ackint;
  int           m_lvl, m_ackline;

  // returns kind*16 + index; kind 0 none, 1 internal, 2 external
  function automatic int m_pick();
    int r = 0;
    for (int i = N - 1; i >= 0; i--)
      if (m_pext[i] && m_mask[i] && (!m_blk || i < m_lvl)) r = 32 + i;
    for (int k = 2; k >= 0; k--)
      if (m_pint[k]) r = 16 + k;
    return r;
  endfunction

  always @(posedge clk) begin : model
    int p;
    bit acc;
    if (!rst_n) begin
      m_pint = '0; m_pext = '0; m_mask = '0; m_old = '0;
      m_blk = 0; m_lvl = 0; m_ack = 0; m_ackint = 0; m_ackline = 0;
    end else begin
      p   = m_pick();
      acc = (p != 0) && irq_ready;
      m_ack = acc;
      if (acc) begin
        m_ackint  = (p / 16 == 1);
        m_ackline = p % 16;
      end
      m_pint = (m_pint | int_req) & ~((acc && p / 16 == 1) ? (3'b001 << (p % 16)) : 3'b000);
      m_pext = (m_pext | ext_req) & ~ext_clr;
      if (mask_xchg) begin m_old = m_mask; m_mask = mask_wdata; end
      else if (mask_ld) m_mask = mask_wdata;
      if (blk_set) m_lvl = 0;
      else if (acc && p / 16 == 2) m_lvl = p % 16;
      m_blk = (m_blk && !blk_clr) || blk_set || (acc && p / 16 == 2);
    end
  end

  always @(negedge clk) begin : compare
    int p;
    if (rst_n && !done) begin
      p = m_pick();
      chk("R2", "cyc irq_valid", 32'(irq_valid), 32'(p != 0));
      if (p != 0)
        chk("R4", "cyc irq_vec", 32'(irq_vec), (p / 16 == 1) ? 32'(16 + p % 16) : 32'(64 + p % 16));
      chk("R6", "cyc ack_valid", 32'(ack_valid), 32'(m_ack));
      if (m_ack) begin
        chk("R6", "cyc ack_int", 32'(ack_int), 32'(m_ackint));
        chk("R6", "cyc ack_line", 32'(ack_line), 32'(m_ackline));
      end
      chk("R10", "cyc mask_old", 32'(mask_old), 32'(m_old));
    end
  end

  task automatic idle();
    ext_req = '0; ext_clr = '0; int_req = '0; mask_ld = 0; mask_xchg = 0;
    blk_set = 0; blk_clr = 0; irq_ready = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset irq_valid", 32'(irq_valid), 32'd0);
    chk("R1", "reset ack_valid", 32'(ack_valid), 32'd0);
    chk("R1", "reset mask_old", 32'(mask_old), 32'd0);

    ext_req = 8'h04; step();
    chk("R3", "masked line 2 hidden", 32'(irq_valid), 32'd0);

    mask_wdata = 8'hFF; mask_ld = 1; step();
    chk("R2", "line 2 captured vec", 32'(irq_vec), 32'h42);
    chk("R10", "load keeps mask_old", 32'(mask_old), 32'd0);

    ext_req = 8'h22; step();
    chk("R4", "line 1 wins over 2,5", 32'(irq_vec), 32'h41);

    irq_ready = 1; step();
    chk("R6", "ack after take", 32'(ack_valid), 32'd1);
    chk("R6", "ack_int external", 32'(ack_int), 32'd0);
    chk("R6", "ack_line 1", 32'(ack_line), 32'd1);
    chk("R7", "lines 1,2,5 held", 32'(irq_valid), 32'd0);
    step();
    chk("R6", "ack one cycle", 32'(ack_valid), 32'd0);

    ext_req = 8'h01; step();
    chk("R7", "line 0 outranks block", 32'(irq_vec), 32'h40);

    ext_clr = 8'h01; blk_clr = 1; step();
    chk("R2", "line 1 still pending after service", 32'(irq_vec), 32'h41);

    blk_set = 1; blk_clr = 1; step();
    chk("R8", "set beats clear, all held", 32'(irq_valid), 32'd0);

    int_req = 3'b110; mask_wdata = 8'h00; mask_ld = 1; step();
    chk("R5", "trap beats cerr, ignores block", 32'(irq_vec), 32'h11);

    irq_ready = 1; step();
    chk("R6", "internal ack_int", 32'(ack_int), 32'd1);
    chk("R6", "internal ack_line", 32'(ack_line), 32'd1);
    chk("R5", "cerr next", 32'(irq_vec), 32'h12);
    irq_ready = 1; step();
    chk("R6", "cerr ack_line", 32'(ack_line), 32'd2);
    chk("R5", "internals drained", 32'(irq_valid), 32'd0);

    mask_wdata = 8'h0F; mask_xchg = 1; step();
    chk("R10", "xchg returns old 00", 32'(mask_old), 32'h00);
    mask_wdata = 8'h30; mask_xchg = 1; mask_ld = 1; step();
    chk("R10", "xchg returns old 0F", 32'(mask_old), 32'h0F);

    blk_clr = 1; step();
    chk("R3", "mask 30 passes line 5", 32'(irq_vec), 32'h45);
    ext_req = 8'h20; ext_clr = 8'h20; step();
    chk("R9", "clear beats level", 32'(irq_valid), 32'd0);
    step();
    chk("R9", "stays cleared", 32'(irq_valid), 32'd0);
    ext_req = 8'h20; step();
    chk("R2", "recapture line 5", 32'(irq_vec), 32'h45);
    int_req = 3'b111; step();
    chk("R5", "power failure first", 32'(irq_vec), 32'h10);

    for (int c = 0; c < 3000; c++) begin
      ext_req    = N'($urandom & $urandom & $urandom);
      ext_clr    = ($urandom % 4 == 0) ? N'($urandom & $urandom) : '0;
      int_req    = ($urandom % 24 == 0) ? 3'($urandom) : 3'b000;
      mask_wdata = N'($urandom);
      mask_ld    = ($urandom % 10 == 0);
      mask_xchg  = ($urandom % 25 == 0);
      blk_set    = ($urandom % 30 == 0);
      blk_clr    = ($urandom % 6 == 0);
      irq_ready  = ($urandom % 2 == 0);
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule